// File: doc/BRIEF.md
# Two-Lane Parity-Steered Fetch and Issue

This block is the front end of an in-order pipeline that issues up to two instructions per cycle. Each cycle it presents one aligned pair address to instruction memory and receives two 32-bit words together. It latches them into a decode-stage pair register. The word at the lower (even) word address always fills lane 0, and the word at the upper (odd) word address always fills lane 1. There is no dependency-based pairing. Lane placement depends only on address parity, and the two lanes move forward together as one unit.

When control arrives on an odd word, for example after a taken branch to an odd target, the lane 0 slot of that pair is marked invalid. Only lane 1 carries an instruction in that case. Branches and jumps of every kind are resolved in the execute stage, which sends back a target address with a valid strobe. On that strobe the front end drops the pair it is fetching and the pair waiting in decode, then fetches from the target. A stall input freezes the fetch address and the decode pair. The redirect strobe overrides the stall.

Top module: `fetch_pair_issue`

## Requirements
- R1: While reset is active, and in the first cycle after it, all lane valid bits are 0 and the fetch address `imem_addr` is 0.
- R2: In a cycle with neither stall nor redirect, `imem_addr` advances by the pair size (8 bytes). `imem_addr` always has bits [2:0] clear.
- R3: A loaded pair puts `imem_rdata[31:0]` (the word at `imem_addr`) into lane 0 with PC equal to `imem_addr`. It puts `imem_rdata[63:32]` into lane 1 with PC equal to `imem_addr`+4. The PCs are packed into `dec_pc` and the words into `dec_instr`, each with lane 0 in the low 32 bits.
- R4: A pair fetched from an even word address (fetch PC bit 2 = 0) loads with `dec_valid` = 2'b11.
- R5: A pair fetched from an odd word address (fetch PC bit 2 = 1) loads with `dec_valid` = 2'b10, meaning lane 1 is valid and lane 0 is not.
- R6: In a cycle with stall high and no redirect, `imem_addr` and all decode outputs, including the valid bits, keep their values.
- R7: A redirect makes `dec_valid` 2'b00 in the next cycle. It also sets the fetch PC to the target, so `imem_addr` becomes the target with bits [2:0] cleared. The pair loaded after that follows the target's parity.
- R8: A redirect in the same cycle as a stall still takes effect exactly as in R7.
- R9: Bits [1:0] of the redirect target are ignored. The target's word parity (bit 2) alone chooses R4 or R5 for the first pair.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| stall | input | 1 | Freeze fetch and the decode pair |
| redirect_valid | input | 1 | Execute-stage redirect strobe |
| redirect_pc | input | 32 | Redirect target byte address |
| imem_addr | output | 32 | Aligned pair address sent to instruction memory |
| imem_rdata | input | 64 | Pair read back; lane 0 word in bits [31:0] |
| dec_valid | output | 2 | Per-lane valid toward decode, bit i for lane i |
| dec_pc | output | 64 | Per-lane PC, lane 0 in bits [31:0] |
| dec_instr | output | 64 | Per-lane instruction, lane 0 in bits [31:0] |

## Verification
The stall and the redirect can both arrive in one cycle. The bench provokes this in two ways. In one, a redirect and a stall are raised together while a valid pair sits in decode. In the other, the redirect lands on a pending pair and a stall follows, holding the flushed state. The bench judges the result by whether the valid bits clear and the fetch address jumps to the target in the next cycle, instead of both staying frozen. A second overlap is a redirect to an odd word arriving during a stall. Here the bench confirms that the later pair still comes in with only lane 1 valid.

// File: rtl/fpi_pkg.sv
package fpi_pkg;

    // How the front end moves on a given clock edge.
    typedef enum logic [1:0] {
        ADV_STEP = 2'd0,  // load fetched pair, step PC by one pair
        ADV_HOLD = 2'd1,  // stall: keep everything
        ADV_JUMP = 2'd2   // redirect: flush and load target PC
    } adv_e;

    localparam int unsigned WORD_BYTES = 4;
    localparam int unsigned WORD_OFF_W = 2;

endpackage

// File: rtl/fpi_adv_ctl.sv
module fpi_adv_ctl
    import fpi_pkg::*;
(
    input  logic stall,
    input  logic redirect_valid,
    output adv_e adv
);

    // Redirect outranks stall: a wrong path must never be frozen in place.
    always_comb begin
        if (redirect_valid) begin
            adv = ADV_JUMP;
        end else if (stall) begin
            adv = ADV_HOLD;
        end else begin
            adv = ADV_STEP;
        end
    end

endmodule

// File: rtl/fpi_pc_gen.sv
module fpi_pc_gen
    import fpi_pkg::*;
#(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned LANES  = 2,
    localparam int unsigned PAIR_BYTES = LANES * WORD_BYTES,
    localparam int unsigned OFF_W      = $clog2(PAIR_BYTES),
    localparam int unsigned IDX_W      = $clog2(LANES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  adv_e              adv,
    input  logic [ADDR_W-1:0] redirect_pc,
    output logic [ADDR_W-1:0] base_addr,
    output logic [IDX_W-1:0]  start_idx
);

    typedef struct packed {
        logic [ADDR_W-1:0] pc;
    } pc_state_t;

    pc_state_t st_d, st_q;

    logic [ADDR_W-1:0] base_w;

    always_comb begin
        base_w = {st_q.pc[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
        st_d   = st_q;
        unique case (adv)
            ADV_STEP: st_d.pc = base_w + ADDR_W'(PAIR_BYTES);
            ADV_JUMP: st_d.pc = {redirect_pc[ADDR_W-1:WORD_OFF_W], {WORD_OFF_W{1'b0}}};
            default:  st_d.pc = st_q.pc;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign base_addr = base_w;
    assign start_idx = st_q.pc[OFF_W-1:WORD_OFF_W];

endmodule

// File: rtl/fpi_lane_slot.sv
module fpi_lane_slot
    import fpi_pkg::*;
#(
    parameter int unsigned ADDR_W   = 32,
    parameter int unsigned INSTR_W  = 32,
    parameter int unsigned LANES    = 2,
    parameter int unsigned LANE_IDX = 0,
    localparam int unsigned IDX_W   = $clog2(LANES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  adv_e               adv,
    input  logic [ADDR_W-1:0]  base_addr,
    input  logic [IDX_W-1:0]   start_idx,
    input  logic [INSTR_W-1:0] fetch_word,
    output logic               slot_valid,
    output logic [ADDR_W-1:0]  slot_pc,
    output logic [INSTR_W-1:0] slot_instr
);

    localparam logic [IDX_W-1:0]  MY_IDX = IDX_W'(LANE_IDX);
    localparam logic [ADDR_W-1:0] MY_OFF = ADDR_W'(LANE_IDX * WORD_BYTES);

    typedef struct packed {
        logic               valid;
        logic [ADDR_W-1:0]  pc;
        logic [INSTR_W-1:0] instr;
    } slot_t;

    slot_t sl_d, sl_q;

    always_comb begin
        sl_d = sl_q;
        unique case (adv)
            ADV_STEP: begin
                // A lane below the entry word of the pair carries a bubble.
                sl_d.valid = (MY_IDX >= start_idx);
                sl_d.pc    = base_addr + MY_OFF;
                sl_d.instr = fetch_word;
            end
            ADV_JUMP: sl_d.valid = 1'b0;
            default:  sl_d = sl_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sl_q <= '0;
        end else begin
            sl_q <= sl_d;
        end
    end

    assign slot_valid = sl_q.valid;
    assign slot_pc    = sl_q.pc;
    assign slot_instr = sl_q.instr;

endmodule

// File: rtl/fetch_pair_issue.sv
module fetch_pair_issue
    import fpi_pkg::*;
#(
    parameter int unsigned ADDR_W  = 32,
    parameter int unsigned INSTR_W = 32,
    parameter int unsigned LANES   = 2,
    localparam int unsigned IDX_W  = $clog2(LANES)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       stall,
    input  logic                       redirect_valid,
    input  logic [ADDR_W-1:0]          redirect_pc,
    output logic [ADDR_W-1:0]          imem_addr,
    input  logic [LANES*INSTR_W-1:0]   imem_rdata,
    output logic [LANES-1:0]           dec_valid,
    output logic [LANES*ADDR_W-1:0]    dec_pc,
    output logic [LANES*INSTR_W-1:0]   dec_instr
);

    adv_e              adv;
    logic [ADDR_W-1:0] base_addr;
    logic [IDX_W-1:0]  start_idx;

    fpi_adv_ctl u_adv (
        .stall          (stall),
        .redirect_valid (redirect_valid),
        .adv            (adv)
    );

    fpi_pc_gen #(
        .ADDR_W (ADDR_W),
        .LANES  (LANES)
    ) u_pc (
        .clk         (clk),
        .rst_n       (rst_n),
        .adv         (adv),
        .redirect_pc (redirect_pc),
        .base_addr   (base_addr),
        .start_idx   (start_idx)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        fpi_lane_slot #(
            .ADDR_W   (ADDR_W),
            .INSTR_W  (INSTR_W),
            .LANES    (LANES),
            .LANE_IDX (g)
        ) u_slot (
            .clk        (clk),
            .rst_n      (rst_n),
            .adv        (adv),
            .base_addr  (base_addr),
            .start_idx  (start_idx),
            .fetch_word (imem_rdata[g*INSTR_W +: INSTR_W]),
            .slot_valid (dec_valid[g]),
            .slot_pc    (dec_pc[g*ADDR_W +: ADDR_W]),
            .slot_instr (dec_instr[g*INSTR_W +: INSTR_W])
        );
    end

    assign imem_addr = base_addr;

endmodule

// File: rtl/fpi_checker.sv
module fpi_checker #(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned LANES  = 2
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    stall,
    input logic                    redirect_valid,
    input logic [ADDR_W-1:0]       redirect_pc,
    input logic [ADDR_W-1:0]       imem_addr,
    input logic [LANES-1:0]        dec_valid,
    input logic [LANES*ADDR_W-1:0] dec_pc
);

    localparam int unsigned PAIR_BYTES = LANES * 4;
    localparam logic [ADDR_W-1:0] PAIR_STEP = ADDR_W'(PAIR_BYTES);
    localparam logic [ADDR_W-1:0] ALIGN_MSK = ~(PAIR_STEP - ADDR_W'(1));

    AST_STEP_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (!stall && !redirect_valid) |=> imem_addr == $past(imem_addr) + PAIR_STEP); // R2

    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (stall && !redirect_valid) |=> ($stable(imem_addr) && $stable(dec_valid) && $stable(dec_pc))); // R6

    AST_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_valid |=> dec_valid == '0); // R7

    AST_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_valid |=> imem_addr == ($past(redirect_pc) & ALIGN_MSK)); // R8

    AST_LANE_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid[0] |-> dec_valid[LANES-1]); // R5

    AST_LANE_PC: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid[0] |-> dec_pc[ADDR_W +: ADDR_W] == dec_pc[0 +: ADDR_W] + ADDR_W'(4)); // R3

endmodule

bind fetch_pair_issue fpi_checker #(
    .ADDR_W (ADDR_W),
    .LANES  (LANES)
) u_fpi_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .stall          (stall),
    .redirect_valid (redirect_valid),
    .redirect_pc    (redirect_pc),
    .imem_addr      (imem_addr),
    .dec_valid      (dec_valid),
    .dec_pc         (dec_pc)
);

// File: tb/tb_fetch_pair_issue.sv
module tb_fetch_pair_issue;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        stall = 1'b0;
    logic        redirect_valid = 1'b0;
    logic [31:0] redirect_pc = '0;
    logic [31:0] imem_addr;
    logic [63:0] imem_rdata;
    logic [1:0]  dec_valid;
    logic [63:0] dec_pc;
    logic [63:0] dec_instr;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    function automatic logic [31:0] mem_word(input logic [31:0] a);
        return 32'hC0DE_0000 ^ (a * 32'h0000_9E37) ^ {a[15:0], 16'h0};
    endfunction

    assign imem_rdata = {mem_word(imem_addr + 32'd4), mem_word(imem_addr)};

    fetch_pair_issue dut (
        .clk            (clk),
        .rst_n          (rst_n),
        .stall          (stall),
        .redirect_valid (redirect_valid),
        .redirect_pc    (redirect_pc),
        .imem_addr      (imem_addr),
        .imem_rdata     (imem_rdata),
        .dec_valid      (dec_valid),
        .dec_pc         (dec_pc),
        .dec_instr      (dec_instr)
    );

    task automatic cmp(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Compare outputs against an expected pair state (lane 0 PC given).
    task automatic check_state(input string req, input logic [31:0] e_addr,
                               input logic [1:0] e_vld, input logic [31:0] e_pc0);
        cmp(req, "imem_addr", imem_addr, e_addr);
        cmp(req, "dec_valid", {30'd0, dec_valid}, {30'd0, e_vld});
        for (int l = 0; l < 2; l++) begin
            if (e_vld[l]) begin
                cmp(req, "lane pc", dec_pc[l*32 +: 32], e_pc0 + 32'(l * 4));
                cmp(req, "lane instr", dec_instr[l*32 +: 32], mem_word(e_pc0 + 32'(l * 4)));
            end
        end
    endtask

    typedef struct packed {
        logic        stl;
        logic        rdv;
        logic [31:0] rpc;
        logic [31:0] addr;
        logic [1:0]  vld;
        logic [31:0] pc0;
        logic [15:0] req;
    } vec_t;

    localparam int NV = 15;
    localparam vec_t TBL [NV] = '{
        '{1'b0, 1'b0, 32'h0,     32'h008, 2'b11, 32'h000, "R2"}, // step from 0
        '{1'b0, 1'b0, 32'h0,     32'h010, 2'b11, 32'h008, "R3"}, // next pair
        '{1'b1, 1'b0, 32'h0,     32'h010, 2'b11, 32'h008, "R6"}, // stall holds
        '{1'b1, 1'b0, 32'h0,     32'h010, 2'b11, 32'h008, "R6"}, // stall again
        '{1'b0, 1'b1, 32'h104,   32'h100, 2'b00, 32'h0,   "R7"}, // odd target
        '{1'b0, 1'b0, 32'h0,     32'h108, 2'b10, 32'h100, "R5"}, // lane 0 bubble
        '{1'b0, 1'b0, 32'h0,     32'h110, 2'b11, 32'h108, "R4"}, // full pair
        '{1'b1, 1'b1, 32'h200,   32'h200, 2'b00, 32'h0,   "R8"}, // redirect over stall
        '{1'b1, 1'b0, 32'h0,     32'h200, 2'b00, 32'h0,   "R6"}, // stall keeps flush
        '{1'b0, 1'b0, 32'h0,     32'h208, 2'b11, 32'h200, "R4"}, // even target
        '{1'b0, 1'b1, 32'h40B,   32'h408, 2'b00, 32'h0,   "R9"}, // low bits set
        '{1'b0, 1'b0, 32'h0,     32'h410, 2'b11, 32'h408, "R9"}, // even parity kept
        '{1'b0, 1'b1, 32'h7FC,   32'h7F8, 2'b00, 32'h0,   "R7"}, // odd target again
        '{1'b1, 1'b0, 32'h0,     32'h7F8, 2'b00, 32'h0,   "R6"}, // stall while pending
        '{1'b0, 1'b0, 32'h0,     32'h800, 2'b10, 32'h7F8, "R5"}  // odd entry after stall
    };

    task automatic step_cycle(input logic s, input logic r, input logic [31:0] t);
        stall = s;
        redirect_valid = r;
        redirect_pc = t;
        @(posedge clk);
        @(negedge clk);
        stall = 1'b0;
        redirect_valid = 1'b0;
        redirect_pc = '0;
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check_state("R1", 32'h0, 2'b00, 32'h0); // during reset
        rst_n = 1'b1;
        check_state("R1", 32'h0, 2'b00, 32'h0); // first cycle after reset

        for (int i = 0; i < NV; i++) begin
            step_cycle(TBL[i].stl, TBL[i].rdv, TBL[i].rpc);
            check_state(string'(TBL[i].req), TBL[i].addr, TBL[i].vld, TBL[i].pc0);
        end

        // R1: reset in mid-run clears valids and fetch address
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check_state("R1", 32'h0, 2'b00, 32'h0);
        rst_n = 1'b1;

        // R5: redirect to odd word before any step after reset
        step_cycle(1'b0, 1'b1, 32'h14);
        check_state("R7", 32'h10, 2'b00, 32'h0);
        step_cycle(1'b0, 1'b0, 32'h0);
        check_state("R5", 32'h18, 2'b10, 32'h10);

        // R8: redirect+stall with valid pair in decode, then normal flow
        step_cycle(1'b0, 1'b0, 32'h0);
        check_state("R2", 32'h20, 2'b11, 32'h18);
        step_cycle(1'b1, 1'b1, 32'h3C);
        check_state("R8", 32'h38, 2'b00, 32'h0);
        step_cycle(1'b0, 1'b0, 32'h0);
        check_state("R5", 32'h40, 2'b10, 32'h38);

        done = 1'b1;
        finish_run();
    end

    initial begin
        repeat (2000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            finish_run();
        end
    end

endmodule